// File: doc/BRIEF.md
# Shutdown and Output-Enable Controller

This block turns one shared control pin into a chip-wide power-down request or an output-enable signal, depending on a configuration bit. When the pin is used as an output enable its active level can be chosen by a second configuration bit. In the power-down role the active level is fixed. The block combines the decoded pin with two per-channel configuration bits and produces a drive state for each output channel: active, tri-state, or parked at its idle level.

The pin has a weak pull-down on the board, so an unconnected pin reads as 0. It is brought into the reference clock domain through a synchronizer. The power-down flag is registered and, once raised, stays up for a minimum number of reference cycles. A channel never changes state in the middle of a clock pulse. A new state is applied only on the reference edge that first samples that channel's clock low after it was high, so an output cannot emit a runt pulse. Differential channels park high on the true side and low on the complement side. Single-ended channels park low. The `idle_hi_o` output reports the true-side level.

Top module: `sdoe_ctrl`

## Requirements
- R1: After reset, `sd_o` is 0, every channel state is tri-state (code 01), and `idle_hi_o` is 0.
- R2: With `sh_mode_i`=1, a 1 on `pin_i` raises `sd_o` on the third rising reference edge after the pin changes (two synchronizer stages plus the flag register). `pol_hi_i` has no effect in this role.
- R3: Once `sd_o` rises, it stays high for at least `SD_HOLD` cycles. A single-cycle synchronized pulse keeps it high for exactly `SD_HOLD` cycles.
- R4: While `sd_o` is 1, every channel moves to the idle state (code 10) at its next applied edge, whatever its enable bits are. `idle_hi_o[i]` is then 1 for a differential channel (bit i of `DIFF_MASK` set) and 0 for a single-ended channel.
- R5: With `sh_mode_i`=0, the enable is asserted when the synchronized pin equals `pol_hi_i`. So `pol_hi_i`=0 means active low and 1 means active high. With `sh_mode_i`=1 and the pin low, the enable counts as asserted.
- R6: When the enable is asserted and there is no power-down, a channel is active (code 00).
- R7: When the enable is deasserted and `os_i[i]`=0, channel i is tri-stated (code 01), whatever `oe_i[i]` is.
- R8: When the enable is deasserted and `os_i[i]`=1, channel i is idle (code 10) if `oe_i[i]`=1. It stays active if `oe_i[i]`=0, because the pin has no effect on that channel.
- R9: A channel's state changes only on a rising reference edge at which `ch_clk_i[i]` is sampled 0 and was sampled 1 on the previous edge. The state is visible right after that edge.
- R10: Each channel occupies bits [2i+1:2i] of `state_o`, and code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Shared shutdown / output-enable pin |
| sh_mode_i | input | 1 | 1: the pin requests power-down; 0: the pin is an output enable |
| pol_hi_i | input | 1 | Output-enable polarity: 0 active low, 1 active high |
| oe_i | input | N_OUT | Per-channel bit: the pin controls this channel |
| os_i | input | N_OUT | Per-channel bit: 0 tri-states the channel when it is disabled |
| ch_clk_i | input | N_OUT | Each channel's output clock, as seen in the reference domain |
| sd_o | output | 1 | Registered power-down flag |
| state_o | output | 2*N_OUT | Per-channel drive state: 00 active, 01 tri-state, 10 idle |
| idle_hi_o | output | N_OUT | True-side level of an idle channel |

## Verification
A pin change reaches the enable decode two edges later and reaches `sd_o` three edges later. A channel state follows only on the edge that samples a falling channel clock. The bench therefore holds every channel clock high for six cycles after each stimulus, which leaves time for the synchronizer and the power-down hold. Before releasing the clocks it checks that no channel state has moved. It then drives the clocks low for one edge and compares all states and idle levels half a cycle later against values computed by its own model. The hold time is measured separately by counting the cycles during which `sd_o` is high after a single-cycle pin pulse.

// File: rtl/sdoe_pkg.sv
package sdoe_pkg;
   typedef enum logic [1:0] {
      DRV_ACTIVE = 2'b00,
      DRV_TRI    = 2'b01,
      DRV_IDLE   = 2'b10
   } drv_state_e;
endpackage

// File: rtl/sdoe_pin_decode.sv
module sdoe_pin_decode #(
   parameter int SYNC_STAGES = 2,
   parameter int SD_HOLD     = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   input  logic sh_mode_i,
   input  logic pol_hi_i,
   output logic sd_o,
   output logic en_o
);
   localparam int CntW = (SD_HOLD < 2) ? 1 : $clog2(SD_HOLD + 1);
   localparam int AgeW = CntW + 1;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end
   if (SD_HOLD < 1) begin : g_bad_hold
      $error("SD_HOLD must be at least 1");
   end

   logic pin_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_s = pin_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sync_q <= '0;
         end else begin
            for (int k = SYNC_STAGES - 1; k > 0; k--) begin
               sync_q[k] <= sync_q[k-1];
            end
            sync_q[0] <= pin_i;
         end
      end
      assign pin_s = sync_q[SYNC_STAGES-1];
   end

   logic            raw_sd;
   logic            sd_q;
   logic [CntW-1:0] hold_q;

   assign raw_sd = sh_mode_i & pin_s;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sd_q   <= 1'b0;
         hold_q <= '0;
      end else begin
         if (raw_sd) begin
            sd_q   <= 1'b1;
            hold_q <= CntW'(SD_HOLD - 1);
         end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
         end else begin
            sd_q <= 1'b0;
         end
      end
   end

   assign sd_o = sd_q;
   assign en_o = sh_mode_i ? 1'b1 : (pin_s == pol_hi_i);

   // Checker state: cycles elapsed since sd_q rose, saturating
   logic [AgeW-1:0] age_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         age_q <= '0;
      end else if (!sd_q) begin
         age_q <= '0;
      end else if (age_q != {AgeW{1'b1}}) begin
         age_q <= age_q + 1'b1;
      end
   end

   // R3
   sd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sd_q) |-> ($past(age_q) >= AgeW'(SD_HOLD - 1)));

   // R2
   sd_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sd_q) |-> $past(sh_mode_i && pin_s));
endmodule

// File: rtl/sdoe_chan_policy.sv
module sdoe_chan_policy
   import sdoe_pkg::*;
(
   input  logic       sd_i,
   input  logic       en_i,
   input  logic       oe_i,
   input  logic       os_i,
   output drv_state_e target_o
);
   always_comb begin
      if (sd_i) begin
         target_o = DRV_IDLE;
      end else if (en_i) begin
         target_o = DRV_ACTIVE;
      end else if (!os_i) begin
         target_o = DRV_TRI;
      end else if (oe_i) begin
         target_o = DRV_IDLE;
      end else begin
         target_o = DRV_ACTIVE;
      end
   end
endmodule

// File: rtl/sdoe_chan_gate.sv
module sdoe_chan_gate
   import sdoe_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ch_clk_i,
   input  drv_state_e target_i,
   output drv_state_e state_o,
   output logic       fall_o
);
   logic       ch_q;
   drv_state_e state_q;

   assign fall_o = ch_q & ~ch_clk_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ch_q    <= 1'b0;
         state_q <= DRV_TRI;
      end else begin
         ch_q <= ch_clk_i;
         if (fall_o) begin
            state_q <= target_i;
         end
      end
   end

   assign state_o = state_q;

   // R9
   chan_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(state_q) |-> $past(fall_o));

   // R10
   chan_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != 2'b11);
endmodule

// File: rtl/sdoe_ctrl.sv
module sdoe_ctrl
   import sdoe_pkg::*;
#(
   parameter int               N_OUT       = 4,
   parameter int               SYNC_STAGES = 2,
   parameter int               SD_HOLD     = 2,
   parameter logic [N_OUT-1:0] DIFF_MASK   = 4'b0101
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               pin_i,
   input  logic               sh_mode_i,
   input  logic               pol_hi_i,
   input  logic [N_OUT-1:0]   oe_i,
   input  logic [N_OUT-1:0]   os_i,
   input  logic [N_OUT-1:0]   ch_clk_i,
   output logic               sd_o,
   output logic [2*N_OUT-1:0] state_o,
   output logic [N_OUT-1:0]   idle_hi_o
);
   if (N_OUT < 1) begin : g_bad_count
      $error("N_OUT must be at least 1");
   end

   logic sd_w;
   logic en_w;

   sdoe_pin_decode #(
      .SYNC_STAGES (SYNC_STAGES),
      .SD_HOLD     (SD_HOLD)
   ) u_decode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pin_i),
      .sh_mode_i (sh_mode_i),
      .pol_hi_i  (pol_hi_i),
      .sd_o      (sd_w),
      .en_o      (en_w)
   );

   assign sd_o = sd_w;

   for (genvar i = 0; i < N_OUT; i++) begin : g_chan
      drv_state_e target_w;
      drv_state_e state_w;
      logic       fall_w;

      sdoe_chan_policy u_policy (
         .sd_i     (sd_w),
         .en_i     (en_w),
         .oe_i     (oe_i[i]),
         .os_i     (os_i[i]),
         .target_o (target_w)
      );

      sdoe_chan_gate u_gate (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .ch_clk_i (ch_clk_i[i]),
         .target_i (target_w),
         .state_o  (state_w),
         .fall_o   (fall_w)
      );

      assign state_o[2*i+1:2*i] = state_w;

      if (DIFF_MASK[i]) begin : g_diff
         assign idle_hi_o[i] = (state_w == DRV_IDLE);
      end else begin : g_single
         assign idle_hi_o[i] = 1'b0;
      end

      // R4
      sd_forces_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(fall_w) && $past(sd_w)) |-> (state_w == DRV_IDLE));
   end
endmodule

// File: tb/sdoe_ctrl_tb.sv
module sdoe_ctrl_tb_top;
   localparam int               N       = 4;
   localparam int               HOLD    = 2;
   localparam logic [N-1:0]     DMASK   = 4'b0101;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           pin = 1'b0;
   logic           sh = 1'b0;
   logic           pol = 1'b0;
   logic [N-1:0]   oe = '0;
   logic [N-1:0]   os = '0;
   logic [N-1:0]   chc = '1;
   logic           sd;
   logic [2*N-1:0] st;
   logic [N-1:0]   idh;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [2*N-1:0] prev_exp;

   always #4 clk = ~clk;

   sdoe_ctrl #(.N_OUT(N), .SYNC_STAGES(2), .SD_HOLD(HOLD), .DIFF_MASK(DMASK)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sh_mode_i(sh), .pol_hi_i(pol),
      .oe_i(oe), .os_i(os), .ch_clk_i(chc), .sd_o(sd), .state_o(st), .idle_hi_o(idh));

   function automatic logic [1:0] exp_chan(input logic s, input logic p, input logic pl,
                                           input logic o_e, input logic o_s);
      logic en;
      if (s && p) return 2'b10;
      en = s ? 1'b1 : (p == pl);
      if (en) return 2'b00;
      if (!o_s) return 2'b01;
      return o_e ? 2'b10 : 2'b00;
   endfunction

   function automatic logic [2*N-1:0] exp_all(input logic s, input logic p, input logic pl,
                                              input logic [N-1:0] o_e, input logic [N-1:0] o_s);
      logic [2*N-1:0] r;
      for (int i = 0; i < N; i++) r[2*i +: 2] = exp_chan(s, p, pl, o_e[i], o_s[i]);
      return r;
   endfunction

   function automatic logic [N-1:0] exp_idh(input logic [2*N-1:0] s);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = (s[2*i +: 2] == 2'b10) && DMASK[i];
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Drive stimulus, settle with channel clocks high, verify no change, then release one fall.
   task automatic apply(input logic s, input logic p, input logic pl,
                        input logic [N-1:0] o_e, input logic [N-1:0] o_s, input string req);
      logic [2*N-1:0] e;
      @(negedge clk);
      sh = s; pin = p; pol = pl; oe = o_e; os = o_s; chc = '1;
      repeat (6) @(negedge clk);
      check("R9 hold before fall", 32'(st), 32'(prev_exp));
      check("R2 sd level", 32'(sd), 32'(s & p));
      chc = '0;
      @(negedge clk);
      e = exp_all(s, p, pl, o_e, o_s);
      check(req, 32'(st), 32'(e));
      check("R4 idle level", 32'(idh), 32'(exp_idh(e)));
      prev_exp = e;
      chc = '1;
   endtask

   initial begin
      void'($urandom(32'd1234));
      prev_exp = {N{2'b01}};
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 sd", 32'(sd), 0);
      check("R1 state", 32'(st), 32'({N{2'b01}}));
      check("R1 idle", 32'(idh), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 no fall yet", 32'(st), 32'({N{2'b01}}));

      // Directed: R5/R6 active low enable asserted
      apply(0, 0, 0, 4'b1111, 4'b1111, "R6 enabled active");
      // R8 disabled, os=1 oe mix
      apply(0, 1, 0, 4'b0011, 4'b1111, "R8 disabled idle vs ignore");
      // R7 disabled, os=0 tri whatever oe
      apply(0, 1, 0, 4'b1010, 4'b0000, "R7 tri regardless of oe");
      // R5 active high polarity
      apply(0, 1, 1, 4'b1111, 4'b1111, "R5 active high enabled");
      apply(0, 0, 1, 4'b1111, 4'b0101, "R5 active high disabled");
      // R2/R4 shutdown, polarity ignored
      apply(1, 1, 0, 4'b0000, 4'b0000, "R4 shutdown idle");
      apply(1, 1, 1, 4'b1111, 4'b1111, "R4 shutdown pol ignored");
      apply(1, 0, 1, 4'b1111, 4'b0000, "R5 sh mode pin low active");

      // R2 latency: sd rises on third edge
      @(negedge clk);
      sh = 1; pin = 0; chc = '1;
      repeat (3) @(negedge clk);
      pin = 1;
      repeat (2) @(negedge clk);
      check("R2 sd not yet", 32'(sd), 0);
      @(negedge clk);
      check("R2 sd after third edge", 32'(sd), 1);
      pin = 0;
      repeat (6) @(negedge clk);
      check("R2 sd cleared", 32'(sd), 0);

      // R3 single-cycle pulse holds exactly HOLD cycles
      begin
         int cnt = 0;
         pin = 1;
         @(negedge clk);
         pin = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (sd) cnt++;
         end
         check("R3 hold length", 32'(cnt), 32'(HOLD));
      end

      // Random mix
      for (int it = 0; it < 300; it++) begin
         logic [31:0] r;
         r = $urandom;
         apply(r[0], r[1], r[2], r[7:4], r[11:8], "R6 R7 R8 random");
      end

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule